// File: doc/BRIEF.md
# Modify-and-Test Counter Unit

This unit carries out the read-modify-write step behind single-instruction interrupt service. One start pulse latches an address, an operand size, a signed modifier and two context flags. The unit reads the operand from memory, adds the modifier at the chosen width, writes the sum back to the same location and reports whether the new value is zero. The operand size is a byte, a halfword or a full word.

A flag marks the operation as running inside an interrupt location. In that case the unit has no visible side effects beyond the memory update. The condition code is left as it was, no overflow trap is raised and any protection fault signalled at start is disregarded. Outside that context the condition code follows the result, overflow raises a trap request, and a protection fault aborts the operation before memory is touched.

A second flag marks a count-pulse level. If the result of such an operation is zero, the unit pulses a counter-equals-zero interrupt request together with its done strobe.

Top module: `mt_counter_unit`

## Requirements
- R1: Size code 0 selects byte, 1 selects halfword, and 2 or 3 select word. Only the modifier's low bits at that width take part. A byte sum wraps modulo 256 and appears zero-extended on `result`. Halfword and word sums are two's complement at their own width, with the halfword sign-extended on `result`.
- R2: A started operation makes exactly one read, then exactly one write to the same address. The write carries byte-lane mask 0001 for a byte, 0011 for a halfword and 1111 for a word (bit k covers data bits 8k+7..8k), so bytes outside the operand are preserved. Read and write requests are never high together.
- R3: `done` pulses one cycle after the cycle in which the write request meets its acknowledge. With single-cycle memory acknowledges this is six cycles after the start cycle. A `start` that arrives while `busy` is high is ignored.
- R4: Outside interrupt context, `cc` is loaded with the done strobe as {negative, zero, positive, overflow} in bits 3..0. A byte result is never negative and never overflows.
- R5: In interrupt context, `cc` keeps its previous value, even when the addition overflows.
- R6: Outside interrupt context, a signed overflow of a halfword or word addition pulses `ovf_trap` with `done`.
- R7: In interrupt context, `ovf_trap` is never raised.
- R8: A start with `prot_fault` high outside interrupt context makes no memory access and leaves `cc` unchanged. It pulses `prot_trap` and `done` one cycle after the start cycle.
- R9: In interrupt context, `prot_fault` is ignored: the operation runs normally and `prot_trap` stays low.
- R10: `zero` reports a zero result at the done strobe. When the operation was started with `count_pulse` high and the result is zero, `cez_req` pulses with `done`.
- R11: After reset, `busy`, `done`, the memory requests, `cc` and all trap and request pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (ignored while busy) |
| op_size | input | 2 | Operand size code |
| op_addr | input | ADDR_W | Operand address |
| modifier | input | 4*BYTE_W | Signed value added to the operand |
| intr_ctx | input | 1 | Operation runs in an interrupt location |
| count_pulse | input | 1 | Operation serves a count-pulse level |
| prot_fault | input | 1 | Protection or write-lock check failed for this access |
| mem_rd_req | output | 1 | Read request, held until acknowledged |
| mem_wr_req | output | 1 | Write request, held until acknowledged |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | 4*BYTE_W | Write data |
| mem_wmask | output | 4 | Byte-lane write enables |
| mem_rdata | input | 4*BYTE_W | Read data, valid with the read acknowledge |
| mem_rd_ack | input | 1 | Read acknowledge |
| mem_wr_ack | input | 1 | Write acknowledge |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 4*BYTE_W | Modified value |
| zero | output | 1 | Result was zero |
| cc | output | 4 | Condition code {N,Z,P,V} |
| ovf_trap | output | 1 | Fixed-point overflow trap request |
| prot_trap | output | 1 | Protection violation trap request |
| cez_req | output | 1 | Counter-equals-zero interrupt request |

## Verification
Overflow and a zero result can come from the same addition. This happens when the most negative halfword or word is added to itself, so the overflow trap and the counter-equals-zero request can fall due on the same done strobe. The sweep reaches this case with the minimum-value pattern as both operand and modifier, under every combination of context and count-pulse flags. With the interrupt-context flag high, the cycle must show the counter-zero request, no overflow trap and an unchanged condition code. With the flag low, it must show both pulses and a condition code holding Z and V together. A protection fault arriving together with the interrupt-context flag is also driven, to confirm that the context flag wins.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_CALC  = 2'd2,
    ST_WRITE = 2'd3
  } state_e;

  typedef struct packed {
    logic neg;
    logic zer;
    logic pos;
    logic ovf;
  } flags_t;
endpackage

// File: rtl/mt_alu.sv
`timescale 1ns/1ps
module mt_alu
  import mt_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  size_e                 size,
  input  logic [4*BYTE_W-1:0]   opnd,
  input  logic [4*BYTE_W-1:0]   modf,
  output logic [4*BYTE_W-1:0]   res,
  output flags_t                flags
);
  localparam int BW = BYTE_W;
  localparam int HW = 2 * BYTE_W;
  localparam int DW = 4 * BYTE_W;

  logic [BW-1:0] sum_b;
  logic [HW-1:0] sum_h;
  logic [DW-1:0] sum_w;

  always_comb begin
    sum_b = opnd[BW-1:0] + modf[BW-1:0];
    sum_h = opnd[HW-1:0] + modf[HW-1:0];
    sum_w = opnd + modf;
    res   = '0;
    flags = '0;
    case (size)
      SZ_BYTE: begin
        // unsigned, wraps, never negative, never overflows
        res       = {{(DW-BW){1'b0}}, sum_b};
        flags.zer = (sum_b == '0);
      end
      SZ_HALF: begin
        res       = {{(DW-HW){sum_h[HW-1]}}, sum_h};
        flags.neg = sum_h[HW-1];
        flags.zer = (sum_h == '0);
        flags.ovf = (opnd[HW-1] == modf[HW-1]) && (sum_h[HW-1] != opnd[HW-1]);
      end
      default: begin
        res       = sum_w;
        flags.neg = sum_w[DW-1];
        flags.zer = (sum_w == '0);
        flags.ovf = (opnd[DW-1] == modf[DW-1]) && (sum_w[DW-1] != opnd[DW-1]);
      end
    endcase
    flags.pos = !flags.neg && !flags.zer;
  end
endmodule

// File: rtl/mt_lane_mask.sv
`timescale 1ns/1ps
module mt_lane_mask
  import mt_pkg::*;
#(
  parameter int LANES = 4
) (
  input  size_e            size,
  output logic [LANES-1:0] mask
);
  localparam int HALF_LANES = LANES / 2;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam bit IN_BYTE = (k == 0);
    localparam bit IN_HALF = (k < HALF_LANES);
    assign mask[k] = (size == SZ_BYTE) ? IN_BYTE :
                     (size == SZ_HALF) ? IN_HALF : 1'b1;
  end
endmodule

// File: rtl/mt_flag_reg.sv
`timescale 1ns/1ps
module mt_flag_reg
  import mt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd,
  input  logic       hold,
  input  flags_t     flags,
  output logic [3:0] cc
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cc <= '0;
    end else if (upd && !hold) begin
      cc <= flags;
    end
  end
endmodule

// File: rtl/mt_seq.sv
`timescale 1ns/1ps
module mt_seq
  import mt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  size_e             size_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mod_i,
  input  logic              ctx_i,
  input  logic              cp_i,
  input  logic              prot_fault_i,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_wmask,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rd_ack,
  input  logic              mem_wr_ack,
  output size_e             size_q,
  output logic [DATA_W-1:0] opnd_q,
  output logic [DATA_W-1:0] mod_q,
  input  logic [DATA_W-1:0] alu_res,
  input  flags_t            alu_flags,
  input  logic [LANES-1:0]  lane_mask,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic              ovf_trap,
  output logic              prot_trap,
  output logic              cez_req,
  output logic              flag_upd,
  output flags_t            flags_q,
  output logic              ctx_q
);
  state_e state;
  logic   cp_q;

  assign busy     = (state != ST_IDLE);
  assign flag_upd = (state == ST_WRITE) && mem_wr_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_rd_req <= 1'b0;
      mem_wr_req <= 1'b0;
      mem_addr   <= '0;
      mem_wdata  <= '0;
      mem_wmask  <= '0;
      size_q     <= SZ_BYTE;
      opnd_q     <= '0;
      mod_q      <= '0;
      flags_q    <= '0;
      ctx_q      <= 1'b0;
      cp_q       <= 1'b0;
      done       <= 1'b0;
      result     <= '0;
      zero       <= 1'b0;
      ovf_trap   <= 1'b0;
      prot_trap  <= 1'b0;
      cez_req    <= 1'b0;
    end else begin
      done      <= 1'b0;
      ovf_trap  <= 1'b0;
      prot_trap <= 1'b0;
      cez_req   <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            size_q   <= size_i;
            mem_addr <= addr_i;
            mod_q    <= mod_i;
            ctx_q    <= ctx_i;
            cp_q     <= cp_i;
            if (prot_fault_i && !ctx_i) begin
              // abort before any memory access
              done      <= 1'b1;
              prot_trap <= 1'b1;
            end else begin
              mem_rd_req <= 1'b1;
              state      <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (mem_rd_ack) begin
            opnd_q     <= mem_rdata;
            mem_rd_req <= 1'b0;
            state      <= ST_CALC;
          end
        end
        ST_CALC: begin
          mem_wdata  <= alu_res;
          mem_wmask  <= lane_mask;
          flags_q    <= alu_flags;
          mem_wr_req <= 1'b1;
          state      <= ST_WRITE;
        end
        ST_WRITE: begin
          if (mem_wr_ack) begin
            mem_wr_req <= 1'b0;
            mem_wmask  <= '0;
            state      <= ST_IDLE;
            done       <= 1'b1;
            result     <= mem_wdata;
            zero       <= flags_q.zer;
            ovf_trap   <= flags_q.ovf && !ctx_q;
            cez_req    <= cp_q && flags_q.zer;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mt_counter_unit.sv
`timescale 1ns/1ps
module mt_counter_unit
  import mt_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16,
  localparam int DATA_W = 4 * BYTE_W,
  localparam int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [1:0]        op_size,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [DATA_W-1:0] modifier,
  input  logic              intr_ctx,
  input  logic              count_pulse,
  input  logic              prot_fault,
  output logic              mem_rd_req,
  output logic              mem_wr_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [LANES-1:0]  mem_wmask,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_rd_ack,
  input  logic              mem_wr_ack,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] result,
  output logic              zero,
  output logic [3:0]        cc,
  output logic              ovf_trap,
  output logic              prot_trap,
  output logic              cez_req
);
  size_e             size_in;
  size_e             size_q;
  logic [DATA_W-1:0] opnd_q;
  logic [DATA_W-1:0] mod_q;
  logic [DATA_W-1:0] alu_res;
  flags_t            alu_flags;
  flags_t            flags_q;
  logic [LANES-1:0]  lane_mask;
  logic              flag_upd;
  logic              ctx_q;

  assign size_in = size_e'(op_size);

  mt_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LANES(LANES)) u_seq (
    .clk(clk), .rst(rst), .start(start), .size_i(size_in), .addr_i(op_addr),
    .mod_i(modifier), .ctx_i(intr_ctx), .cp_i(count_pulse), .prot_fault_i(prot_fault),
    .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wmask(mem_wmask), .mem_rdata(mem_rdata),
    .mem_rd_ack(mem_rd_ack), .mem_wr_ack(mem_wr_ack),
    .size_q(size_q), .opnd_q(opnd_q), .mod_q(mod_q),
    .alu_res(alu_res), .alu_flags(alu_flags), .lane_mask(lane_mask),
    .busy(busy), .done(done), .result(result), .zero(zero),
    .ovf_trap(ovf_trap), .prot_trap(prot_trap), .cez_req(cez_req),
    .flag_upd(flag_upd), .flags_q(flags_q), .ctx_q(ctx_q)
  );

  mt_alu #(.BYTE_W(BYTE_W)) u_alu (
    .size(size_q), .opnd(opnd_q), .modf(mod_q), .res(alu_res), .flags(alu_flags)
  );

  mt_lane_mask #(.LANES(LANES)) u_mask (
    .size(size_q), .mask(lane_mask)
  );

  mt_flag_reg u_cc (
    .clk(clk), .rst(rst), .upd(flag_upd), .hold(ctx_q), .flags(flags_q), .cc(cc)
  );
endmodule

// File: rtl/mt_counter_unit_chk.sv
`timescale 1ns/1ps
module mt_counter_unit_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       prot_fault,
  input logic       intr_ctx,
  input logic       busy,
  input logic       done,
  input logic       zero,
  input logic [3:0] cc,
  input logic       ovf_trap,
  input logic       prot_trap,
  input logic       cez_req,
  input logic       mem_rd_req,
  input logic       mem_wr_req,
  input logic       mem_wr_ack,
  input logic       ctx_q
);
  a_r2_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_req && mem_wr_req));

  a_r3_done_after_wack: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_req && mem_wr_ack) |=> done);

  a_r4_zero_in_cc: assert property (@(posedge clk) disable iff (rst)
    (done && !ctx_q && !prot_trap) |-> (cc[2] == zero));

  a_r5_cc_hold: assert property (@(posedge clk) disable iff (rst)
    (done && ctx_q) |-> (cc == $past(cc)));

  a_r6_ovf_flag: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> cc[0]);

  a_r7_no_ovf_trap: assert property (@(posedge clk) disable iff (rst)
    ovf_trap |-> (done && !ctx_q));

  a_r8_prot_abort: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && prot_fault && !intr_ctx) |=> (done && prot_trap && !mem_rd_req && (cc == $past(cc))));

  a_r9_prot_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && prot_fault && intr_ctx) |=> (mem_rd_req && !prot_trap));

  a_r10_cez: assert property (@(posedge clk) disable iff (rst)
    cez_req |-> (done && zero));
endmodule

bind mt_counter_unit mt_counter_unit_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .prot_fault(prot_fault), .intr_ctx(intr_ctx),
  .busy(busy), .done(done), .zero(zero), .cc(cc), .ovf_trap(ovf_trap),
  .prot_trap(prot_trap), .cez_req(cez_req), .mem_rd_req(mem_rd_req),
  .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack), .ctx_q(ctx_q)
);

// File: tb/sim_mt_counter_unit.sv
`timescale 1ns/1ps
module sim_mt_counter_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op_size = 2'd0;
  logic [15:0] op_addr = 16'd0;
  logic [31:0] modifier = 32'd0;
  logic        intr_ctx = 1'b0;
  logic        count_pulse = 1'b0;
  logic        prot_fault = 1'b0;
  logic        mem_rd_req, mem_wr_req;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [3:0]  mem_wmask;
  logic [31:0] mem_rdata = 32'd0;
  logic        mem_rd_ack = 1'b0;
  logic        mem_wr_ack = 1'b0;
  logic        busy, done, zero, ovf_trap, prot_trap, cez_req;
  logic [31:0] result;
  logic [3:0]  cc;

  always #2 clk = ~clk;

  mt_counter_unit u0 (
    .clk(clk), .rst(rst), .start(start), .op_size(op_size), .op_addr(op_addr),
    .modifier(modifier), .intr_ctx(intr_ctx), .count_pulse(count_pulse),
    .prot_fault(prot_fault), .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wmask(mem_wmask),
    .mem_rdata(mem_rdata), .mem_rd_ack(mem_rd_ack), .mem_wr_ack(mem_wr_ack),
    .busy(busy), .done(done), .result(result), .zero(zero), .cc(cc),
    .ovf_trap(ovf_trap), .prot_trap(prot_trap), .cez_req(cez_req)
  );

  // memory model with single-cycle acknowledges
  logic [31:0] mem [0:15];
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = 4'd0;
  logic [31:0] ld_data = 32'd0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;

  always @(posedge clk) begin
    if (ld_en) mem[ld_idx] <= ld_data;
    mem_rd_ack <= mem_rd_req && !mem_rd_ack;
    if (mem_rd_req && !mem_rd_ack) begin
      mem_rdata <= mem[mem_addr[3:0]];
      rd_cnt <= rd_cnt + 1;
    end
    mem_wr_ack <= mem_wr_req && !mem_wr_ack;
    if (mem_wr_req && !mem_wr_ack) begin
      for (int k = 0; k < 4; k++)
        if (mem_wmask[k]) mem[mem_addr[3:0]][8*k +: 8] <= mem_wdata[8*k +: 8];
      wr_cnt <= wr_cnt + 1;
    end
  end

  int nchk = 0;
  int nerr = 0;
  bit fin = 1'b0;
  logic [3:0] exp_cc = 4'd0;
  logic [31:0] seed = 32'h1234_5678;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] nxt();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed;
  endfunction

  function automatic logic [31:0] pat(input int k, input logic [31:0] wm);
    case (k)
      0: return 32'd0;
      1: return 32'd1;
      2: return 32'hFFFF_FFFF;
      3: return wm >> 1;
      4: return (wm >> 1) + 32'd1;
      5: return 32'd2;
      6: return wm - 32'd1;
      default: return 32'(k) * 32'h9E37_79B1 ^ (32'(k) << 11);
    endcase
  endfunction

  task automatic load(input logic [3:0] idx, input logic [31:0] d);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic run_op(input int sz, input logic [3:0] idx, input logic [31:0] m,
                        input logic ctx, input logic cp, input logic pf, output int lat);
    @(negedge clk);
    start = 1'b1; op_size = sz[1:0]; op_addr = {12'd0, idx}; modifier = m;
    intr_ctx = ctx; count_pulse = cp; prot_fault = pf;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (!done) begin
      nchk++; nerr++;
      $display("FAIL R3: timeout actual=no done expected=done");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!fin) begin
      nerr++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    int lat;
    int r0, w0;
    logic [31:0] wm, a, m, fill, er, emem;
    logic eo, en, ez, ep;
    int s16;
    longint s32;

    for (int i = 0; i < 16; i++) mem[i] = 32'd0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 busy", 32'(busy), 32'd0);
    chk("R11 done", 32'(done), 32'd0);
    chk("R11 cc", 32'(cc), 32'd0);
    chk("R11 req", {30'd0, mem_rd_req, mem_wr_req}, 32'd0);
    chk("R11 pulses", {29'd0, ovf_trap, prot_trap, cez_req}, 32'd0);

    // near-exhaustive sweep: size x operand x modifier x context x count-pulse
    for (int sz = 0; sz < 3; sz++) begin
      wm = (sz == 0) ? 32'h0000_00FF : (sz == 1) ? 32'h0000_FFFF : 32'hFFFF_FFFF;
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          for (int c = 0; c < 4; c++) begin
            logic ctx, cp;
            logic [3:0] idx;
            ctx = c[0];
            cp  = c[1];
            idx = 4'((i + j) % 16);
            a = pat(i, wm) & wm;
            m = (pat(j, wm) & wm) | (nxt() & ~wm);
            fill = (nxt() & ~wm) | a;
            load(idx, fill);
            if (sz == 0) begin
              er = (a + m) & 32'h0000_00FF;
              eo = 1'b0; en = 1'b0;
            end else if (sz == 1) begin
              s16 = $signed(a[15:0]) + $signed(m[15:0]);
              eo = (s16 > 32767) || (s16 < -32768);
              er = {{16{s16[15]}}, s16[15:0]};
              en = s16[15];
            end else begin
              s32 = longint'($signed(a)) + longint'($signed(m));
              eo = (s32 > 64'sd2147483647) || (s32 < -64'sd2147483648);
              er = s32[31:0];
              en = er[31];
            end
            ez = ((er & wm) == 32'd0);
            ep = !en && !ez;
            if (!ctx) exp_cc = {en, ez, ep, eo};
            emem = (fill & ~wm) | (er & wm);
            r0 = rd_cnt; w0 = wr_cnt;
            run_op(sz, idx, m, ctx, cp, 1'b0, lat);
            chk("R3 latency", 32'(lat), 32'd6);
            chk("R1 result", result, er);
            chk("R10 zero", 32'(zero), 32'(ez));
            chk(ctx ? "R5 cc held" : "R4 cc update", 32'(cc), 32'(exp_cc));
            chk(ctx ? "R7 no ovf trap" : "R6 ovf trap", 32'(ovf_trap), 32'(eo && !ctx));
            chk("R10 cez", 32'(cez_req), 32'(cp && ez));
            chk("R8 no prot trap", 32'(prot_trap), 32'd0);
            @(negedge clk);
            chk("R2 memory", mem[idx], emem);
            chk("R2 one read one write", 32'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 32'd17);
          end
        end
      end
    end

    // R1 size code 3 behaves as word
    load(4'd3, 32'h7FFF_FFFF);
    run_op(3, 4'd3, 32'd1, 1'b0, 1'b0, 1'b0, lat);
    exp_cc = 4'b1001;
    chk("R1 code3 result", result, 32'h8000_0000);
    chk("R6 code3 ovf", 32'(ovf_trap), 32'd1);
    chk("R4 code3 cc", 32'(cc), 32'(exp_cc));

    // R8 protection fault outside context aborts
    load(4'd5, 32'hA5A5_0010);
    r0 = rd_cnt; w0 = wr_cnt;
    run_op(2, 4'd5, 32'd1, 1'b0, 1'b1, 1'b1, lat);
    chk("R8 latency", 32'(lat), 32'd1);
    chk("R8 prot trap", 32'(prot_trap), 32'd1);
    chk("R8 cc unchanged", 32'(cc), 32'(exp_cc));
    chk("R8 no cez", 32'(cez_req), 32'd0);
    @(negedge clk);
    chk("R8 no access", 32'((rd_cnt - r0) + (wr_cnt - w0)), 32'd0);
    chk("R8 memory kept", mem[5], 32'hA5A5_0010);

    // R9 protection fault ignored in interrupt context
    run_op(2, 4'd5, 32'd1, 1'b1, 1'b0, 1'b1, lat);
    chk("R9 latency", 32'(lat), 32'd6);
    chk("R9 no prot trap", 32'(prot_trap), 32'd0);
    @(negedge clk);
    chk("R9 memory", mem[5], 32'hA5A5_0011);

    // R3 start while busy is ignored
    load(4'd6, 32'h0000_0040);
    load(4'd7, 32'h0000_0070);
    w0 = wr_cnt;
    @(negedge clk);
    start = 1'b1; op_size = 2'd0; op_addr = 16'd6; modifier = 32'd1;
    intr_ctx = 1'b1; count_pulse = 1'b0; prot_fault = 1'b0;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1; op_addr = 16'd7; modifier = 32'd5;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin @(negedge clk); lat++; end
    chk("R3 busy op result", result, 32'h0000_0041);
    repeat (3) @(negedge clk);
    chk("R3 second start ignored", mem[7], 32'h0000_0070);
    chk("R3 single write", 32'(wr_cnt - w0), 32'd1);
    chk("R3 idle after", 32'(busy), 32'd0);

    fin = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule